// File: doc/BRIEF.md
# Addressable Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single line and presents them to a host through a two-entry receive buffer. A frame is a low start bit, eight data bits sent least significant bit first, an optional ninth bit, and one stop bit. The block oversamples the line using an external tick that runs at sixteen times the bit rate. The line first passes through a two-stage synchronizer. A start bit is recognised on a falling edge and is confirmed at the middle of the bit. After that, every following bit is sampled at its centre.

The ninth bit can tag a frame as an address in a multidrop network. When address filtering is on, frames whose ninth bit is clear are dropped with no trace. This lets a node ignore traffic meant for other nodes until it is addressed.

Each buffered entry carries its own framing-error flag. If a frame completes while both entries are still unread, the block raises a sticky overrun flag. The flag holds until the host turns the receiver off. While it is set, further frames are dropped. The host pops entries with a one-cycle read strobe.

Top module: `uart_addr_rx`

## Requirements
- R1: While `port_en_i` is 0 the line is treated as idle: no frame is received whatever `rx_i` does.
- R2: While `rx_en_i` is 0 the receiver is off. Frames sent during that time do not change `avail_o`.
- R3: An 8-bit frame (low start bit, eight bits LSB first, high stop bit) puts its byte on `data_o` and raises `avail_o`. In this mode `bit9_o` reads 0.
- R4: When `nine_bit_i` is 1, the bit that follows data bit 7 is stored with the byte and shown on `bit9_o`.
- R5: With `addr_det_i` = 1 in 9-bit mode, a frame whose ninth bit is 0 is discarded and a frame whose ninth bit is 1 is stored. With `addr_det_i` = 0 every frame is stored.
- R6: A stop bit sampled as 0 sets `frame_err_o` for that entry only. The flag follows the entry at the head of the buffer.
- R7: Up to two frames are held, oldest first. A read strobe while `avail_o` is 1 removes the head entry. `avail_o` is 0 when the buffer is empty and after reset, and `data_o`, `overrun_o` and `frame_err_o` reset to 0.
- R8: A frame that completes and would be stored while both entries are full, with no read in that cycle, sets `overrun_o` and is lost. While `overrun_o` is 1, later frames are also lost.
- R9: `overrun_o` stays 1 until `rx_en_i` is 0. It is 0 in the cycle after `rx_en_i` is seen low. Buffered entries are kept.
- R10: A low pulse that has ended by the middle of the start bit is ignored, and the receiver then accepts the next real frame.
- R11: A new frame starts only on a falling edge. A line held low after a frame with a bad stop bit yields no further frames until it has returned high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Serial line, asynchronous |
| tick16_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| port_en_i | input | 1 | Connects the line to the receiver |
| rx_en_i | input | 1 | Receiver on; low also clears overrun |
| nine_bit_i | input | 1 | 1 = frames carry a ninth bit |
| addr_det_i | input | 1 | 1 = drop 9-bit frames whose ninth bit is 0 |
| rd_i | input | 1 | Pops the head entry |
| data_o | output | 8 | Head entry data byte |
| bit9_o | output | 1 | Head entry ninth bit |
| avail_o | output | 1 | Buffer holds at least one entry |
| frame_err_o | output | 1 | Head entry had a bad stop bit |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench targets these corner cases:
- A third frame arriving while both entries are full. A wrong design would overwrite the oldest entry or keep accepting frames after the overrun flag is set.
- Clearing the overrun flag. A wrong design would clear it on a read instead of only on a receiver disable.
- A bad stop bit followed by a long low level. A design that starts frames on a low level instead of a falling edge would store phantom bytes.
- A glitch shorter than half a bit. A design without the midpoint check would store a phantom byte.
- Address filtering. A wrong design would let zero-tagged frames raise `avail_o`, or would filter when the filter is off.

// File: rtl/uart_rx_pkg.sv
// Package: shared types for the addressable serial receiver.
// Assumes an 8-bit data byte; the ninth bit is carried separately.
package uart_rx_pkg;
    localparam int DATA_W = 8;

    // One buffered reception: byte, ninth bit, framing error
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              ferr;
    } rx_word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;
endpackage

// File: rtl/rx_sync.sv
// Module: rx_sync
// Brings the asynchronous serial line into the clock domain through a
// chain of flops. While the port is disabled the line is forced to idle
// (high). Assumes STAGES >= 2.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] chain;

    // First stage: take the gated line, idle high on reset
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= en ? line_i : 1'b1;
    end

    // Remaining stages, one flop each
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign line_o = chain[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
// Module: rx_frame
// Oversampling frame decoder. Waits for a falling edge seen on tick
// boundaries, confirms the start bit at half a bit period, samples each
// data bit every OVERSAMPLE ticks, then samples the stop bit and emits a
// one-cycle done pulse with the assembled word. Assumes the line is
// already synchronous and that tick is a single-cycle pulse.
module rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active,
    input  logic     tick,
    input  logic     line,
    input  logic     nine_mode,
    output logic     done,
    output logic     nine_q,
    output rx_word_t word
);
    localparam int CNT_W  = $clog2(OVERSAMPLE);
    localparam int HALF   = OVERSAMPLE / 2;
    localparam int BIT_W  = $clog2(DATA_W + 2);

    rx_state_t          state;
    logic [CNT_W-1:0]   cnt;
    logic [BIT_W-1:0]   bitn;
    logic [DATA_W:0]    shreg;
    logic               armed;
    logic [BIT_W-1:0]   last_bit;

    // Index of the final data bit for the mode latched at start
    assign last_bit = nine_q ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);

    // Frame sequencer: start detect, bit sampling, stop check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            armed  <= 1'b0;
            nine_q <= 1'b0;
            done   <= 1'b0;
            word   <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                state <= ST_IDLE;
                cnt   <= '0;
                armed <= 1'b0;
            end else if (tick) begin
                unique case (state)
                    ST_IDLE: begin
                        if (line) begin
                            armed <= 1'b1;
                        end else if (armed) begin
                            state  <= ST_START;
                            cnt    <= '0;
                            armed  <= 1'b0;
                            nine_q <= nine_mode;
                        end
                    end
                    ST_START: begin
                        if (cnt == CNT_W'(HALF - 1)) begin
                            cnt <= '0;
                            if (!line) begin
                                state <= ST_DATA;
                                bitn  <= '0;
                            end else begin
                                state <= ST_IDLE;
                                armed <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == CNT_W'(OVERSAMPLE - 1)) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[DATA_W:1]};
                            bitn  <= bitn + 1'b1;
                            if (bitn == last_bit) state <= ST_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (cnt == CNT_W'(OVERSAMPLE - 1)) begin
                            cnt       <= '0;
                            state     <= ST_IDLE;
                            armed     <= line;
                            done      <= 1'b1;
                            word.data <= nine_q ? shreg[DATA_W-1:0]
                                                : shreg[DATA_W:1];
                            word.bit9 <= nine_q & shreg[DATA_W];
                            word.ferr <= ~line;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_buffer.sv
// Module: rx_buffer
// Small first-in first-out store for received words with a sticky
// overrun flag. A push that finds the store full (after any same-cycle
// pop) sets the flag and is lost; pushes are then refused until the
// flag is cleared. Assumes DEPTH >= 2.
module rx_buffer
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  rx_word_t push_word,
    input  logic     pop,
    input  logic     ovr_clr,
    output rx_word_t head,
    output logic     not_empty,
    output logic     overrun
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_word_t         mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_pop, do_push, full_eff, ovr_set;

    // Decide what happens to this cycle's push and pop
    always_comb begin
        do_pop   = pop && (count != '0);
        full_eff = (count == CNT_W'(DEPTH)) && !do_pop;
        do_push  = push && !overrun && !full_eff;
        ovr_set  = push && !overrun && full_eff;
    end

    // Storage write, reset to zero so the head reads 0 after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (do_push) begin
            mem[wr_ptr] <= push_word;
        end
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // Sticky overrun: set on a lost push, cleared only by ovr_clr
    always_ff @(posedge clk) begin
        if (!rst_n)       overrun <= 1'b0;
        else if (ovr_clr) overrun <= 1'b0;
        else if (ovr_set) overrun <= 1'b1;
    end

    assign head      = mem[rd_ptr];
    assign not_empty = (count != '0);
endmodule

// File: rtl/uart_addr_rx.sv
// Module: uart_addr_rx (top)
// Asynchronous serial receiver with 8/9-bit frames, ninth-bit address
// filtering, per-entry framing error and sticky overrun. Assumes
// tick16_i pulses for one clock at OVERSAMPLE times the bit rate and
// that mode inputs change only while the line is idle.
module uart_addr_rx
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int BUF_DEPTH   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              tick16_i,
    input  logic              port_en_i,
    input  logic              rx_en_i,
    input  logic              nine_bit_i,
    input  logic              addr_det_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              bit9_o,
    output logic              avail_o,
    output logic              frame_err_o,
    output logic              overrun_o
);
    logic     line_s;
    logic     active;
    logic     frm_done;
    logic     frm_nine;
    rx_word_t frm_word;
    logic     keep;
    rx_word_t head;

    assign active = port_en_i & rx_en_i;

    rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (port_en_i),
        .line_i (rx_i),
        .line_o (line_s)
    );

    rx_frame #(.OVERSAMPLE(OVERSAMPLE)) i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .tick      (tick16_i),
        .line      (line_s),
        .nine_mode (nine_bit_i),
        .done      (frm_done),
        .nine_q    (frm_nine),
        .word      (frm_word)
    );

    // Address filter: drop 9-bit frames tagged as data when enabled
    always_comb begin
        keep = frm_done && !(addr_det_i && frm_nine && !frm_word.bit9);
    end

    rx_buffer #(.DEPTH(BUF_DEPTH)) i_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (keep),
        .push_word (frm_word),
        .pop       (rd_i),
        .ovr_clr   (~rx_en_i),
        .head      (head),
        .not_empty (avail_o),
        .overrun   (overrun_o)
    );

    assign data_o      = head.data;
    assign bit9_o      = head.bit9;
    assign frame_err_o = avail_o & head.ferr;
endmodule

// File: rtl/uart_addr_rx_chk.sv
// Module: uart_addr_rx_chk
// Property checker bound to the receiver top.
module uart_addr_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en_i,
    input logic       rd_i,
    input logic       active,
    input logic       frm_done,
    input logic       avail_o,
    input logic [7:0] data_o,
    input logic       overrun_o
);
    // R9: overrun is gone the cycle after the receiver is disabled
    a_r9_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |=> !overrun_o);

    // R9: overrun holds while the receiver stays enabled
    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && rx_en_i) |=> overrun_o);

    // R7: entries leave only through a read
    a_r7_avail_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(avail_o) |-> $past(rd_i));

    // R7: head entry holds while nobody reads
    a_r7_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (avail_o && !rd_i) |=> (avail_o && $stable(data_o)));

    // R2: no frame completes while the receiver is off
    a_r2_no_frame_off: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !frm_done);

    // R8: overrun can rise only while data is waiting
    a_r8_ovr_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> $past(avail_o));
endmodule

bind uart_addr_rx uart_addr_rx_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en_i   (rx_en_i),
    .rd_i      (rd_i),
    .active    (active),
    .frm_done  (frm_done),
    .avail_o   (avail_o),
    .data_o    (data_o),
    .overrun_o (overrun_o)
);

// File: tb/test_uart_addr_rx.sv
// Bench for uart_addr_rx: directed corners plus seeded random frames,
// compared against a software model of the buffer.
module test_uart_addr_rx;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_i = 1'b1;
    logic       tick16_i = 1'b0;
    logic       port_en_i = 1'b1;
    logic       rx_en_i = 1'b1;
    logic       nine_bit_i = 1'b0;
    logic       addr_det_i = 1'b0;
    logic       rd_i = 1'b0;
    logic [7:0] data_o;
    logic       bit9_o, avail_o, frame_err_o, overrun_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Model state
    logic [7:0] m_data [2];
    logic       m_b9   [2];
    logic       m_fe   [2];
    int         m_cnt = 0;
    logic       m_ovr = 1'b0;

    uart_addr_rx i_uart_addr_rx (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tick16_i(tick16_i),
        .port_en_i(port_en_i), .rx_en_i(rx_en_i), .nine_bit_i(nine_bit_i),
        .addr_det_i(addr_det_i), .rd_i(rd_i), .data_o(data_o),
        .bit9_o(bit9_o), .avail_o(avail_o), .frame_err_o(frame_err_o),
        .overrun_o(overrun_o)
    );

    always #5 clk = ~clk;

    // Tick source: one-cycle pulse every TICK_DIV clocks
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            tick16_i = (c == TICK_DIV - 1);
            c = (c == TICK_DIV - 1) ? 0 : c + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit kept(input bit nine, input bit ad, input bit b9);
        return !(ad && nine && !b9);
    endfunction

    // Model: a completed frame under the current modes
    task automatic model_frame(input logic [7:0] d, input bit nine, input bit b9, input bit stop_ok);
        if (rx_en_i && port_en_i && kept(nine, addr_det_i, b9) && !m_ovr) begin
            if (m_cnt == 2) m_ovr = 1'b1;
            else begin
                m_data[m_cnt] = d;
                m_b9[m_cnt]   = nine & b9;
                m_fe[m_cnt]   = !stop_ok;
                m_cnt++;
            end
        end
    endtask

    task automatic model_pop();
        if (m_cnt > 0) begin
            m_data[0] = m_data[1]; m_b9[0] = m_b9[1]; m_fe[0] = m_fe[1];
            m_cnt--;
        end
    endtask

    task automatic compare(input string req);
        @(negedge clk);
        chk(avail_o == (m_cnt != 0), {req, " avail"}, avail_o, m_cnt != 0);
        chk(overrun_o == m_ovr, {req, " overrun"}, overrun_o, m_ovr);
        if (m_cnt != 0) begin
            chk(data_o == m_data[0], {req, " data"}, data_o, m_data[0]);
            chk(bit9_o == m_b9[0], {req, " bit9"}, bit9_o, m_b9[0]);
            chk(frame_err_o == m_fe[0], {req, " ferr"}, frame_err_o, m_fe[0]);
        end
    endtask

    task automatic hold(input logic v, input int clks);
        rx_i = v;
        repeat (clks) @(negedge clk);
    endtask

    // Drive one frame on the line, then one idle bit time
    task automatic send(input logic [7:0] d, input bit nine, input bit b9, input bit stop_ok);
        @(negedge clk);
        nine_bit_i = nine;
        hold(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) hold(d[i], BIT_CLKS);
        if (nine) hold(b9, BIT_CLKS);
        hold(stop_ok, BIT_CLKS);
        hold(1'b1, BIT_CLKS);
        model_frame(d, nine, b9, stop_ok);
    endtask

    task automatic do_read();
        @(negedge clk); rd_i = 1'b1;
        @(negedge clk); rd_i = 1'b0;
        model_pop();
    endtask

    task automatic clear_ovr();
        @(negedge clk); rx_en_i = 1'b0;
        m_ovr = 1'b0;
        repeat (3) @(negedge clk);
        rx_en_i = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(1900000);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd4242);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);

        // R7 reset state
        chk(avail_o == 0, "R7 reset avail", avail_o, 0);
        chk(data_o == 0, "R7 reset data", data_o, 0);
        chk(overrun_o == 0, "R7 reset overrun", overrun_o, 0);
        chk(frame_err_o == 0, "R7 reset ferr", frame_err_o, 0);

        // R3 plain 8-bit frame
        send(8'hA5, 0, 1, 1); compare("R3");
        do_read(); compare("R3 after read");

        // R4 ninth bit
        send(8'h3C, 1, 1, 1); compare("R4");
        do_read();

        // R5 address filtering
        addr_det_i = 1'b1;
        send(8'h11, 1, 0, 1); compare("R5 drop");
        send(8'h22, 1, 1, 1); compare("R5 keep");
        do_read();
        addr_det_i = 1'b0;
        send(8'h33, 1, 0, 1); compare("R5 filter off");
        do_read();

        // R6 framing error, R11 line held low afterwards
        @(negedge clk);
        nine_bit_i = 1'b0;
        hold(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) hold(1'b0, BIT_CLKS);
        hold(1'b0, BIT_CLKS);
        hold(1'b0, 4 * BIT_CLKS);
        hold(1'b1, 2 * BIT_CLKS);
        model_frame(8'h00, 0, 0, 0);
        compare("R6 bad stop R11 single entry");
        do_read(); compare("R11 empty after hold low");
        send(8'h5A, 0, 0, 1); compare("R6 next good frame");
        do_read();

        // R7 ordering, R8 overrun, R9 sticky
        send(8'h01, 0, 0, 1);
        send(8'h02, 0, 0, 1); compare("R7 two held");
        send(8'h03, 0, 0, 1); compare("R8 overrun");
        send(8'h04, 0, 0, 1); compare("R8 dropped while set");
        do_read(); compare("R7 second entry");
        do_read(); compare("R9 still set after reads");
        send(8'h05, 0, 0, 1); compare("R8 dropped while set empty");
        clear_ovr(); compare("R9 cleared by disable");
        send(8'h06, 0, 0, 1); compare("R9 receives again");
        do_read();

        // R2 receiver off
        rx_en_i = 1'b0;
        send(8'h77, 0, 0, 1); compare("R2 off");
        rx_en_i = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);

        // R1 port off
        port_en_i = 1'b0;
        send(8'h88, 0, 0, 1); compare("R1 port off");
        port_en_i = 1'b1;
        repeat (BIT_CLKS) @(negedge clk);

        // R10 glitch shorter than half a bit
        hold(1'b0, 20);
        hold(1'b1, 2 * BIT_CLKS);
        compare("R10 glitch ignored");
        send(8'hC3, 0, 0, 1); compare("R10 next frame");
        do_read();

        // Seeded random frames (R3 R4 R5 R6 R7 R8)
        for (int it = 0; it < 60; it++) begin
            logic [7:0] d;
            bit nine, b9, ok;
            d    = 8'($urandom);
            nine = 1'($urandom);
            b9   = 1'($urandom);
            ok   = ($urandom % 8) != 0;
            addr_det_i = 1'($urandom);
            send(d, nine, b9, ok);
            compare("R5 R8 random frame");
            if (($urandom % 2) == 0 && m_cnt > 0) begin
                do_read(); compare("R7 random read");
            end
            if (m_ovr && ($urandom % 3) == 0) begin
                clear_ovr(); compare("R9 random clear");
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule